// File: doc/BRIEF.md
# CRC-16 Stream Engine with Residue Check

This block computes a 16-bit frame check sequence over a byte stream. It runs in one of two modes on a single shared datapath. In transmit mode it echoes each accepted message byte. After the byte marked last, it appends the two check bytes to its output stream. In receive mode it takes the whole frame, check bytes included, and does not know where the message ends. One cycle after the frame's last byte it reports whether the frame is intact.

The check register is reflected and shifts least significant bit first, with polynomial x^16+x^12+x^5+1 (0x8408 in reflected form). It updates once per accepted byte. A byte flagged as frame start reloads the register to all ones in the same cycle that the byte is absorbed. The transmitted check value is the bitwise complement of the register, sent low byte first.

The receiver does not compare two check values. It pushes the received check bytes through the same engine and compares the result with one fixed nonzero register value. That value appears on the wire as 0x47 then 0x0F, which is register value 0xF0B8.

A small controller sequences the outputs, with three states:
- S_TAKE accepts input with `in_ready` high. A last byte in transmit mode moves it to S_TX_LO. A last byte in receive mode keeps it in S_TAKE and triggers the check.
- S_TX_LO always moves to S_TX_HI.
- S_TX_HI always returns to S_TAKE.

Top module: `crc16_stream`

## Requirements
- R1: During and right after reset, `out_valid`, `out_is_crc`, `chk_valid` and `chk_pass` are low and `in_ready` is high.
- R2: A byte accepted with `in_first` high is processed from a register start value of 0xFFFF, whatever the previous frame left behind. This holds even when frames follow each other without idle cycles.
- R3: In transmit mode (`mode_rx`=0), the two check bytes follow on the two cycles right after the last data byte is echoed. Both are flagged by `out_is_crc`=1. The first is bits 7:0 and the second is bits 15:8 of the complemented register.
- R4: In transmit mode, each accepted byte appears on `out_data` with `out_valid`=1 and `out_is_crc`=0 one cycle after acceptance.
- R5: While the two check bytes are being emitted, `in_ready` is low and any `in_valid` is ignored: no byte is echoed and the register is not changed.
- R6: Message 01 02 03 04 05 06 07 08 yields check bytes D4 then 6D. Message DE AD BE EF yields CB then E5. The ASCII digits "123456789" yield 6E then 90.
- R7: In receive mode (`mode_rx`=1), `chk_valid` pulses high for exactly one cycle, the cycle after the byte flagged `in_last` is accepted.
- R8: `chk_pass` is 1 with `chk_valid` when the register after the last byte equals 0xF0B8. An intact frame whose check bytes are appended low byte first passes. Swapped check bytes, a missing check byte or a corrupted data bit fail.
- R9: `chk_pass` is low whenever `chk_valid` is low, and `chk_valid` never pulses in transmit mode.
- R10: In receive mode `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_rx | input | 1 | 0 selects transmit, 1 selects receive check; held constant within a frame |
| in_valid | input | 1 | Input byte present |
| in_first | input | 1 | Byte is the first of a frame |
| in_last | input | 1 | Byte is the last of the input frame |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Engine can accept a byte this cycle |
| out_valid | output | 1 | Output byte present (transmit mode) |
| out_is_crc | output | 1 | Output byte is a check byte |
| out_data | output | 8 | Output byte |
| chk_valid | output | 1 | One-cycle end-of-frame check strobe (receive mode) |
| chk_pass | output | 1 | Frame residue matched; valid with `chk_valid` |

## Verification
- An echoed byte is due one cycle after the clock edge that accepts it.
- The low and high check bytes are due one and two cycles after the last data echo.
- The receive verdict is due one cycle after the last byte is accepted, and must be gone the cycle after that.

The bench drives inputs on falling edges and reads results on falling edges. A per-cycle monitor records every output byte with its cycle number, so each task can check order and adjacency exactly. The verdict is read at the first falling edge after the accepting edge, and its absence is read at the next one.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    localparam int          CRC_W     = 16;
    localparam int          DATA_W    = 8;
    localparam logic [15:0] POLY_REFL = 16'h8408;
    localparam logic [15:0] INIT_VAL  = 16'hFFFF;
    localparam logic [15:0] XOR_VAL   = 16'hFFFF;
    localparam logic [15:0] GOOD_RES  = 16'hF0B8;

    typedef enum logic [1:0] {
        S_TAKE  = 2'd0,
        S_TX_LO = 2'd1,
        S_TX_HI = 2'd2
    } fsm_t;

endpackage

// File: rtl/crc16_byte_step.sv
module crc16_byte_step #(
    parameter int                 CW   = 16,
    parameter int                 DW   = 8,
    parameter logic [CW-1:0]      POLY = 16'h8408
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] crc_out
);
    // chain[k] holds the register after k bits, least significant bit first
    logic [CW-1:0] chain [0:DW];

    assign chain[0] = crc_in;

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic fb;
        assign fb          = chain[b][0] ^ din[b];
        assign chain[b+1]  = fb ? ((chain[b] >> 1) ^ POLY) : (chain[b] >> 1);
    end

    assign crc_out = chain[DW];

endmodule

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
    import crc16_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_rx,
    input  logic in_valid,
    input  logic in_last,
    output logic in_ready,
    output logic take,
    output logic emit_lo,
    output logic emit_hi,
    output logic end_rx
);
    fsm_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_TAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        in_ready = 1'b0;
        take     = 1'b0;
        emit_lo  = 1'b0;
        emit_hi  = 1'b0;
        end_rx   = 1'b0;
        unique case (state_q)
            S_TAKE: begin
                in_ready = 1'b1;
                take     = in_valid;
                if (in_valid && in_last) begin
                    if (mode_rx) end_rx  = 1'b1;
                    else         state_d = S_TX_LO;
                end
            end
            S_TX_LO: begin
                emit_lo = 1'b1;
                state_d = S_TX_HI;
            end
            S_TX_HI: begin
                emit_hi = 1'b1;
                state_d = S_TAKE;
            end
            default: state_d = S_TAKE;
        endcase
    end

    // R3
    lo_then_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        emit_lo |=> emit_hi);

    // R5
    busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (emit_lo || emit_hi) |-> (!take && !in_ready));

endmodule

// File: rtl/crc16_stream.sv
module crc16_stream
    import crc16_pkg::*;
#(
    parameter int             DW     = DATA_W,
    parameter int             CW     = CRC_W,
    parameter logic [CW-1:0]  POLY   = POLY_REFL,
    parameter logic [CW-1:0]  INIT_V = INIT_VAL,
    parameter logic [CW-1:0]  XOR_V  = XOR_VAL,
    parameter logic [CW-1:0]  RES_V  = GOOD_RES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_rx,
    input  logic          in_valid,
    input  logic          in_first,
    input  logic          in_last,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic          out_is_crc,
    output logic [DW-1:0] out_data,
    output logic          chk_valid,
    output logic          chk_pass
);
    localparam int LO_TOP = DW - 1;
    localparam int HI_BOT = CW - DW;

    logic          take, emit_lo, emit_hi, end_rx;
    logic [CW-1:0] crc_q, crc_seed, crc_next, crc_tx;

    crc16_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_rx  (mode_rx),
        .in_valid (in_valid),
        .in_last  (in_last),
        .in_ready (in_ready),
        .take     (take),
        .emit_lo  (emit_lo),
        .emit_hi  (emit_hi),
        .end_rx   (end_rx)
    );

    assign crc_seed = in_first ? INIT_V : crc_q;

    crc16_byte_step #(.CW(CW), .DW(DW), .POLY(POLY)) u_step (
        .crc_in  (crc_seed),
        .din     (in_data),
        .crc_out (crc_next)
    );

    assign crc_tx = crc_q ^ XOR_V;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    crc_q <= INIT_V;
        else if (take) crc_q <= crc_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_is_crc <= 1'b0;
            out_data   <= '0;
            chk_valid  <= 1'b0;
            chk_pass   <= 1'b0;
        end else begin
            out_valid  <= (take && !mode_rx) || emit_lo || emit_hi;
            out_is_crc <= emit_lo || emit_hi;
            if (take)         out_data <= in_data;
            else if (emit_lo) out_data <= crc_tx[LO_TOP:0];
            else if (emit_hi) out_data <= crc_tx[CW-1:HI_BOT];
            chk_valid  <= end_rx;
            chk_pass   <= end_rx && (crc_next == RES_V);
        end
    end

    // R3
    crc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_is_crc) |=> (out_valid && out_is_crc));

    // R3
    crc_pair_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_is_crc && $past(out_is_crc)) |=> !out_is_crc);

    // R4
    echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !mode_rx) |=> (out_valid && !out_is_crc && out_data == $past(in_data)));

    // R5
    busy_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && !mode_rx) |=> !in_ready);

    // R7
    verdict_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && mode_rx) |=> chk_valid);

    // R7
    verdict_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> !chk_valid);

    // R9
    pass_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |-> !chk_pass);

    // R10
    rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && mode_rx) |=> !out_valid);

endmodule

// File: tb/sim_crc16_stream.sv
module sim_crc16_stream;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_rx, in_valid, in_first, in_last;
    logic [7:0] in_data;
    logic       in_ready, out_valid, out_is_crc, chk_valid, chk_pass;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    crc16_stream u0 (
        .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx), .in_valid(in_valid),
        .in_first(in_first), .in_last(in_last), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_is_crc(out_is_crc),
        .out_data(out_data), .chk_valid(chk_valid), .chk_pass(chk_pass)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [7:0] fr [0:15];
    logic [7:0] cap_d [0:63];
    logic       cap_c [0:63];
    int         cap_t [0:63];
    int         cap_n = 0;
    int         chk_n = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n === 1'b1 && out_valid === 1'b1 && cap_n < 64) begin
            cap_d[cap_n] = out_data;
            cap_c[cap_n] = out_is_crc;
            cap_t[cap_n] = cyc;
            cap_n++;
        end
        if (rst_n === 1'b1 && chk_valid === 1'b1) chk_n++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_fcs(input int n);
        logic [15:0] r;
        logic        fb;
        r = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                fb = r[0] ^ fr[i][b];
                r  = r >> 1;
                if (fb) r = r ^ 16'h8408;
            end
        end
        return ~r;
    endfunction

    task automatic append_fcs(input int n);
        logic [15:0] f;
        f = ref_fcs(n);
        fr[n]   = f[7:0];
        fr[n+1] = f[15:8];
    endtask

    task automatic push(input int n, input logic rx);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            while (in_ready !== 1'b1) @(negedge clk);
            mode_rx  = rx;
            in_valid = 1'b1;
            in_data  = fr[i];
            in_first = (i == 0);
            in_last  = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic tx_case(input int n, input logic use_exp, input logic [7:0] e_lo,
                           input logic [7:0] e_hi, input logic stuff);
        logic [15:0] f;
        cap_n = 0;
        chk_n = 0;
        push(n, 1'b0);
        chk("R5 ready low during first check byte", in_ready, 1'b0);
        if (stuff) begin
            in_valid = 1'b1; in_data = 8'hA5; in_first = 1'b1; in_last = 1'b1;
            @(negedge clk);
            chk("R5 ready low during second check byte", in_ready, 1'b0);
            @(negedge clk);
            in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
        end else begin
            repeat (2) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        f = ref_fcs(n);
        chk("R4 R5 output byte count", cap_n, n + 2);
        for (int i = 0; i < n; i++) begin
            chk("R4 echoed data", cap_d[i], fr[i]);
            chk("R4 data flag", cap_c[i], 1'b0);
        end
        chk("R2 R3 low check byte", cap_d[n], f[7:0]);
        chk("R2 R3 high check byte", cap_d[n+1], f[15:8]);
        chk("R3 check flags", {cap_c[n], cap_c[n+1]}, 2'b11);
        chk("R3 low byte adjacent", cap_t[n] - cap_t[n-1], 1);
        chk("R3 high byte adjacent", cap_t[n+1] - cap_t[n], 1);
        if (use_exp) begin
            chk("R6 vector low byte", cap_d[n], e_lo);
            chk("R6 vector high byte", cap_d[n+1], e_hi);
        end
        chk("R9 no verdict in transmit", chk_n, 0);
    endtask

    task automatic rx_case(input int n, input logic exp_pass);
        cap_n = 0;
        chk_n = 0;
        push(n, 1'b1);
        chk("R7 verdict strobe", chk_valid, 1'b1);
        chk("R8 verdict value", chk_pass, exp_pass);
        @(negedge clk);
        chk("R7 strobe one cycle", chk_valid, 1'b0);
        chk("R9 pass low without strobe", chk_pass, 1'b0);
        repeat (2) @(negedge clk);
        chk("R10 no output in receive", cap_n, 0);
        chk("R7 single pulse", chk_n, 1);
    endtask

    task automatic load_seq8();
        for (int i = 0; i < 8; i++) fr[i] = 8'(i + 1);
    endtask

    task automatic load_dead();
        fr[0] = 8'hDE; fr[1] = 8'hAD; fr[2] = 8'hBE; fr[3] = 8'hEF;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_rx = 1'b0; in_valid = 1'b0;
        in_first = 1'b0; in_last = 1'b0; in_data = 8'h00;
        repeat (3) @(negedge clk);
        // R1
        chk("R1 out_valid in reset", out_valid, 1'b0);
        chk("R1 chk_valid in reset", chk_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", in_ready, 1'b1);
        chk("R1 outputs idle", {out_valid, out_is_crc, chk_valid, chk_pass}, 4'b0000);

        // R6 and R2: back-to-back transmit frames
        load_seq8();
        tx_case(8, 1'b1, 8'hD4, 8'h6D, 1'b0);
        load_dead();
        tx_case(4, 1'b1, 8'hCB, 8'hE5, 1'b0);
        for (int i = 0; i < 9; i++) fr[i] = 8'h31 + 8'(i);
        tx_case(9, 1'b1, 8'h6E, 8'h90, 1'b0);

        // R5: input offered during check emission is ignored
        load_seq8();
        tx_case(8, 1'b1, 8'hD4, 8'h6D, 1'b1);
        fr[0] = 8'h00;
        tx_case(1, 1'b0, 8'h00, 8'h00, 1'b0);

        // R8: good frames pass
        load_seq8(); append_fcs(8);
        rx_case(10, 1'b1);
        load_dead(); append_fcs(4);
        rx_case(6, 1'b1);
        fr[0] = 8'h7E; append_fcs(1);
        rx_case(3, 1'b1);

        // R8: swapped check bytes fail
        load_seq8(); fr[8] = 8'h6D; fr[9] = 8'hD4;
        rx_case(10, 1'b0);
        // R8: missing check byte fails
        load_seq8(); fr[8] = 8'hD4;
        rx_case(9, 1'b0);
        // R8: corrupted data bit fails
        load_dead(); append_fcs(4); fr[2] = fr[2] ^ 8'h10;
        rx_case(6, 1'b0);
        // R8: good frame right after a failing one still passes (R2 reload)
        load_seq8(); append_fcs(8);
        rx_case(10, 1'b1);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule